// File: doc/BRIEF.md
# Masked Configuration Register File

This block holds a 256-byte configuration space for a bus endpoint or bridge as 64 registers of 32 bits. Each register has a fixed writable-bit mask. A software write is merged through that mask, so identity fields such as vendor, device, class and subsystem codes, the header type, the interrupt pin and the low type bits of base address registers keep their reset values. Only the permitted bits take new data.

Writes arrive as one byte, one 16-bit half or one full 32-bit word, addressed by a byte offset. Reads return a full register chosen by index, combinationally, from the state held at the last clock edge. Elaboration parameters set the identity values, the header flavour (endpoint or bridge), the kind and size of up to six address windows, the interrupt routing and whether a capability list is present. Because the low bits of each window register are masked off according to its size, software can write all ones and read back the window size.

Top module: `cfg_space_regfile`

## Requirements
- R1: After reset, register 0 reads {device code, vendor code}, register 2 reads {class[31:24], subclass[23:16], interface[15:8], 8'h00} and register 11 reads {subsystem code[31:16], subsystem vendor[15:0]}. No write changes any of them.
- R2: A write changes only the bits set in the target register's writable mask. In register 1 bits 15:0 are writable and bits 31:16 are read-only. All other bits keep their reset values.
- R3: A byte write (size code 2'b01) changes only byte lane offset[1:0] of register offset[7:2], using data bits 7:0.
- R4: A full-word write (size code 2'b11) takes effect only when offset[1:0] is 0. At any other offset it is dropped and no register changes.
- R5: A half-word write (size code 2'b10) at offset[1:0] of 0 or 2 updates lanes 1:0 or 3:2 from data bits 15:0. At offset[1:0] of 1 or 3 it is dropped.
- R6: With size code 2'b00, or with the write enable low, no register changes.
- R7: A read index of 64 or more returns 32'hFFFFFFFF. A read index in range returns the value as of the last clock edge, so a write is seen by a read in the following cycle.
- R8: In register 3, bits 7:0 are writable. In an endpoint header, bits 23:16 read 0 and only bits 7:0 of register 15 are writable. In a bridge header, bits 23:16 read 1, register 9 has mask 32'hFFF0FFF0 and register 15 has mask 32'hFFFF00FF.
- R9: Window registers are registers 4 to 9. An enabled memory window of size S has mask ~(S-1) with bits 3:0 read-only: bit 3 is the prefetchable flag and bits 2:1 are 2'b10 for a 64-bit window. A disabled slot reads 0 and is read-only.
- R10: An I/O window of size S has mask ~(S-1) with bits 1:0 read-only, and bit 0 reads 1.
- R11: A 64-bit window also claims the next slot for its upper address, with mask ~((S>>32)-1). If the 64-bit flag is set on the last slot, that slot is treated as a 32-bit window.
- R12: When a capability list is present, register 1 bit 20 reads 1 and byte 0x34 (register 13 bits 7:0) reads 0x40. Both are read-only. Without a list, both read 0.
- R13: Register 15 bits 15:8 hold the interrupt pin as a 1-based code (pin index 0..3 reads 1..4) and are read-only. Bits 7:0 hold the writable interrupt line, which resets to its parameter value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset, loads all identity values |
| wr_en | input | 1 | Write strobe |
| wr_off | input | 8 | Byte offset of the write |
| wr_size | input | 2 | Size code: 00 none, 01 byte, 10 half-word, 11 full word |
| wr_data | input | 32 | Write data, right-aligned |
| rd_idx | input | 8 | Register index to read |
| rd_data | output | 32 | Register contents, or all ones when out of range |

## Verification
A write and a read can target the same register in the same cycle. The read must then show the value from before the edge, and the merged value one cycle later. The bench provokes this by holding a full-word write to window register 4 together with a read of index 4. It samples the output once before and once after the clock edge and expects the old window value first, then the masked new one. A second instance built as a bridge header checks the masks that depend on the header flavour.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
    localparam int CFG_DW = 32;

    typedef enum logic [1:0] {
        SZ_NONE  = 2'b00,
        SZ_BYTE  = 2'b01,
        SZ_HALF  = 2'b10,
        SZ_WORD  = 2'b11
    } wsize_e;

    typedef enum logic {
        HDR_ENDPOINT = 1'b0,
        HDR_BRIDGE   = 1'b1
    } hdr_e;

    localparam int IX_IDENT   = 0;
    localparam int IX_CMDSTS  = 1;
    localparam int IX_CLASS   = 2;
    localparam int IX_HDR     = 3;
    localparam int IX_WIN0    = 4;
    localparam int NUM_WIN    = 6;
    localparam int IX_SUBSYS  = 11;
    localparam int IX_CAPPTR  = 13;
    localparam int IX_IRQ     = 15;
    localparam int CAP_BIT    = 20;
    localparam logic [7:0] CAP_FIRST = 8'h40;
endpackage

// File: rtl/cfg_win_slot.sv
module cfg_win_slot #(
    parameter int DW      = 32,
    parameter bit EN      = 1'b0,
    parameter bit IS_IO   = 1'b0,
    parameter bit IS_64   = 1'b0,
    parameter bit PREF    = 1'b0,
    parameter int LOG2    = 12,
    parameter bit UPPER   = 1'b0,
    parameter int UP_LOG2 = 32
) (
    output logic [DW-1:0] init_o,
    output logic [DW-1:0] mask_o
);
    localparam logic [63:0] SZ      = 64'd1 << LOG2;
    localparam logic [63:0] UP_SZ   = 64'd1 << UP_LOG2;
    localparam logic [63:0] LO_MASK = ~(SZ - 64'd1);
    localparam logic [63:0] HI_MASK = ~((UP_SZ >> 32) - 64'd1);
    localparam logic [DW-1:0] KEEP_IO  = ~DW'(3);
    localparam logic [DW-1:0] KEEP_MEM = ~DW'(15);
    localparam logic [DW-1:0] TYPE_MEM = DW'({PREF, IS_64, 2'b00});

    generate
        if (UPPER) begin : g_upper
            assign init_o = '0;
            assign mask_o = HI_MASK[DW-1:0];
        end else if (EN && IS_IO) begin : g_io
            assign init_o = DW'(1);
            assign mask_o = LO_MASK[DW-1:0] & KEEP_IO;
        end else if (EN) begin : g_mem
            assign init_o = TYPE_MEM;
            assign mask_o = LO_MASK[DW-1:0] & KEEP_MEM;
        end else begin : g_off
            assign init_o = '0;
            assign mask_o = '0;
        end
    endgenerate
endmodule

// File: rtl/cfg_layout.sv
module cfg_layout
    import cfg_pkg::*;
#(
    parameter int          DW          = 32,
    parameter int          NREG        = 64,
    parameter hdr_e        HDR         = HDR_ENDPOINT,
    parameter logic [15:0] VEND        = 16'h1234,
    parameter logic [15:0] DEVC        = 16'h5678,
    parameter logic [7:0]  CLS         = 8'h04,
    parameter logic [7:0]  SUBCLS      = 8'h01,
    parameter logic [7:0]  PIF         = 8'h5A,
    parameter logic [15:0] SS_VEND     = 16'hABCD,
    parameter logic [15:0] SS_ID       = 16'h2468,
    parameter bit          CAP_ON      = 1'b1,
    parameter int          IRQ_PIN_IDX = 0,
    parameter logic [7:0]  IRQ_LINE    = 8'h0B,
    parameter logic [NUM_WIN-1:0]   WIN_EN   = 6'b000111,
    parameter logic [NUM_WIN-1:0]   WIN_IO   = 6'b000010,
    parameter logic [NUM_WIN-1:0]   WIN_64   = 6'b000100,
    parameter logic [NUM_WIN-1:0]   WIN_PF   = 6'b000100,
    parameter logic [6*NUM_WIN-1:0] WIN_LOG2 = {6'd0, 6'd0, 6'd0, 6'd33, 6'd8, 6'd12}
) (
    output logic [NREG-1:0][DW-1:0] init_o,
    output logic [NREG-1:0][DW-1:0] wmask_o
);
    logic [NUM_WIN-1:0][DW-1:0] win_init;
    logic [NUM_WIN-1:0][DW-1:0] win_mask;
    logic [NUM_WIN-1:0]         win_used;

    for (genvar s = 0; s < NUM_WIN; s++) begin : g_win
        localparam int P      = (s == 0) ? 0 : s - 1;
        localparam bit EFF64  = WIN_64[s] && (s < NUM_WIN - 1);
        localparam bit PREV64 = WIN_EN[P] && WIN_64[P];
        localparam bit UP     = (s != 0) && PREV64;
        cfg_win_slot #(
            .DW(DW), .EN(WIN_EN[s]), .IS_IO(WIN_IO[s]), .IS_64(EFF64),
            .PREF(WIN_PF[s]), .LOG2(int'(WIN_LOG2[6*s +: 6])),
            .UPPER(UP), .UP_LOG2(int'(WIN_LOG2[6*P +: 6]))
        ) u_slot (
            .init_o(win_init[s]),
            .mask_o(win_mask[s])
        );
        assign win_used[s] = WIN_EN[s] || UP;
    end

    always_comb begin
        init_o  = '0;
        wmask_o = '0;
        init_o[IX_IDENT]  = {DEVC, VEND};
        init_o[IX_CMDSTS] = DW'(CAP_ON) << CAP_BIT;
        wmask_o[IX_CMDSTS] = DW'(16'hFFFF);
        init_o[IX_CLASS]  = {CLS, SUBCLS, PIF, 8'h00};
        init_o[IX_HDR]    = (HDR == HDR_BRIDGE) ? DW'(32'h0001_0000) : '0;
        wmask_o[IX_HDR]   = DW'(8'hFF);
        for (int s = 0; s < NUM_WIN; s++) begin
            init_o[IX_WIN0 + s]  = win_init[s];
            wmask_o[IX_WIN0 + s] = win_mask[s];
        end
        if (HDR == HDR_BRIDGE && !win_used[NUM_WIN-1]) begin
            wmask_o[IX_WIN0 + NUM_WIN - 1] = DW'(32'hFFF0_FFF0);
        end
        init_o[IX_SUBSYS] = {SS_ID, SS_VEND};
        init_o[IX_CAPPTR] = CAP_ON ? DW'(CAP_FIRST) : '0;
        init_o[IX_IRQ]    = {16'h0000, 8'(IRQ_PIN_IDX + 1), IRQ_LINE};
        wmask_o[IX_IRQ]   = (HDR == HDR_BRIDGE) ? DW'(32'hFFFF_00FF) : DW'(8'hFF);
    end
endmodule

// File: rtl/cfg_lane_merge.sv
module cfg_lane_merge
    import cfg_pkg::*;
#(
    parameter int DW    = 32,
    parameter int IDX_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W+$clog2(DW/8)-1:0] wr_off,
    input  logic [1:0]               wr_size,
    input  logic [DW-1:0]            wr_data,
    output logic                     hit_o,
    output logic [IDX_W-1:0]         idx_o,
    output logic [DW/8-1:0]          lanes_o,
    output logic [DW-1:0]            data_o
);
    localparam int NL     = DW / 8;
    localparam int LANE_W = $clog2(NL);

    logic [LANE_W-1:0] lane;
    assign lane  = wr_off[LANE_W-1:0];
    assign idx_o = wr_off[IDX_W+LANE_W-1:LANE_W];

    always_comb begin
        hit_o   = 1'b0;
        lanes_o = '0;
        data_o  = '0;
        case (wsize_e'(wr_size))
            SZ_BYTE: begin
                hit_o   = wr_en;
                lanes_o = NL'(1) << lane;
                data_o  = {{(DW-8){1'b0}}, wr_data[7:0]} << (8 * lane);
            end
            SZ_HALF: begin
                hit_o   = wr_en && !lane[0];
                lanes_o = NL'(3) << lane;
                data_o  = {{(DW-16){1'b0}}, wr_data[15:0]} << (8 * lane);
            end
            SZ_WORD: begin
                hit_o   = wr_en && (lane == '0);
                lanes_o = '1;
                data_o  = wr_data;
            end
            default: begin
                hit_o = 1'b0;
            end
        endcase
    end

    // R3: a byte write selects exactly one lane
    a_r3_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == SZ_BYTE) |-> ($countones(lanes_o) == 1 && hit_o));
endmodule

// File: rtl/cfg_space_regfile.sv
module cfg_space_regfile
    import cfg_pkg::*;
#(
    parameter int          DW          = CFG_DW,
    parameter int          NREG        = 64,
    parameter int          RD_W        = 8,
    parameter hdr_e        HDR         = HDR_ENDPOINT,
    parameter logic [15:0] VEND        = 16'h1234,
    parameter logic [15:0] DEVC        = 16'h5678,
    parameter logic [7:0]  CLS         = 8'h04,
    parameter logic [7:0]  SUBCLS      = 8'h01,
    parameter logic [7:0]  PIF         = 8'h5A,
    parameter logic [15:0] SS_VEND     = 16'hABCD,
    parameter logic [15:0] SS_ID       = 16'h2468,
    parameter bit          CAP_ON      = 1'b1,
    parameter int          IRQ_PIN_IDX = 0,
    parameter logic [7:0]  IRQ_LINE    = 8'h0B,
    parameter logic [NUM_WIN-1:0]   WIN_EN   = 6'b000111,
    parameter logic [NUM_WIN-1:0]   WIN_IO   = 6'b000010,
    parameter logic [NUM_WIN-1:0]   WIN_64   = 6'b000100,
    parameter logic [NUM_WIN-1:0]   WIN_PF   = 6'b000100,
    parameter logic [6*NUM_WIN-1:0] WIN_LOG2 = {6'd0, 6'd0, 6'd0, 6'd33, 6'd8, 6'd12}
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [7:0]      wr_off,
    input  logic [1:0]      wr_size,
    input  logic [DW-1:0]   wr_data,
    input  logic [RD_W-1:0] rd_idx,
    output logic [DW-1:0]   rd_data
);
    localparam int NL     = DW / 8;
    localparam int LANE_W = $clog2(NL);
    localparam int IDX_W  = $clog2(NREG);
    localparam int OFF_W  = IDX_W + LANE_W;

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] regs;
    } state_t;

    state_t st_d, st_q;

    logic [NREG-1:0][DW-1:0] init_v;
    logic [NREG-1:0][DW-1:0] wmask_v;
    logic                    hit;
    logic [IDX_W-1:0]        idx;
    logic [NL-1:0]           lanes;
    logic [DW-1:0]           data_sh;
    logic [DW-1:0]           lane_bits;
    logic [DW-1:0]           eff_mask;

    cfg_layout #(
        .DW(DW), .NREG(NREG), .HDR(HDR), .VEND(VEND), .DEVC(DEVC),
        .CLS(CLS), .SUBCLS(SUBCLS), .PIF(PIF), .SS_VEND(SS_VEND), .SS_ID(SS_ID),
        .CAP_ON(CAP_ON), .IRQ_PIN_IDX(IRQ_PIN_IDX), .IRQ_LINE(IRQ_LINE),
        .WIN_EN(WIN_EN), .WIN_IO(WIN_IO), .WIN_64(WIN_64), .WIN_PF(WIN_PF),
        .WIN_LOG2(WIN_LOG2)
    ) u_layout (
        .init_o (init_v),
        .wmask_o(wmask_v)
    );

    cfg_lane_merge #(.DW(DW), .IDX_W(IDX_W)) u_merge (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_off (wr_off[OFF_W-1:0]),
        .wr_size(wr_size),
        .wr_data(wr_data),
        .hit_o  (hit),
        .idx_o  (idx),
        .lanes_o(lanes),
        .data_o (data_sh)
    );

    for (genvar l = 0; l < NL; l++) begin : g_lane
        assign lane_bits[8*l +: 8] = {8{lanes[l]}};
    end

    assign eff_mask = lane_bits & wmask_v[idx];

    always_comb begin
        st_d = st_q;
        if (hit) begin
            st_d.regs[idx] = (st_q.regs[idx] & ~eff_mask) | (data_sh & eff_mask);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.regs <= init_v;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (32'(rd_idx) < NREG) begin
            rd_data = st_q.regs[rd_idx[IDX_W-1:0]];
        end else begin
            rd_data = '1;
        end
    end

    // R2: read-only bits never leave their reset identity
    a_r2_ro_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.regs & ~wmask_v) == (init_v & ~wmask_v));

    // R4: misaligned full-word write leaves every register unchanged
    a_r4_word_misalign: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == SZ_WORD && wr_off[LANE_W-1:0] != '0) |=> $stable(st_q.regs));

    // R5: half-word write at an odd offset is dropped
    a_r5_half_odd: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == SZ_HALF && wr_off[0]) |=> $stable(st_q.regs));

    // R6: no size or no strobe means no change
    a_r6_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_size == SZ_NONE) |=> $stable(st_q.regs));
endmodule

// File: tb/cfg_space_regfile_test.sv
module cfg_space_regfile_test;
    import cfg_pkg::*;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0]  sz;
        logic [7:0]  off;
        logic [31:0] dat;
        logic [7:0]  ridx;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t TBL [NV] = '{
        '{2'd3, 8'h00, 32'hFFFF_FFFF, 8'd0,  32'h5678_1234, 8'd1},  // R1 identity
        '{2'd3, 8'h04, 32'hFFFF_FFFF, 8'd1,  32'h0010_FFFF, 8'd2},  // R2 command/status
        '{2'd1, 8'h05, 32'h0000_0000, 8'd1,  32'h0010_00FF, 8'd3},  // R3 byte lane 1
        '{2'd2, 8'h06, 32'h0000_FFFF, 8'd1,  32'h0010_00FF, 8'd2},  // R2 status ro
        '{2'd2, 8'h04, 32'h0000_1234, 8'd1,  32'h0010_1234, 8'd5},  // R5 low half
        '{2'd2, 8'h05, 32'h0000_0000, 8'd1,  32'h0010_1234, 8'd5},  // R5 odd drop
        '{2'd3, 8'h06, 32'h0000_0000, 8'd1,  32'h0010_1234, 8'd4},  // R4 misaligned
        '{2'd1, 8'h0C, 32'h0000_0040, 8'd3,  32'h0000_0040, 8'd8},  // R8 cache line
        '{2'd1, 8'h0E, 32'h0000_0055, 8'd3,  32'h0000_0040, 8'd8},  // R8 header ro
        '{2'd3, 8'h10, 32'hFFFF_FFFF, 8'd4,  32'hFFFF_F000, 8'd9},  // R9 size 4K
        '{2'd3, 8'h14, 32'hFFFF_FFFF, 8'd5,  32'hFFFF_FF01, 8'd10}, // R10 io 256
        '{2'd3, 8'h18, 32'hFFFF_FFFF, 8'd6,  32'h0000_000C, 8'd11}, // R11 lower
        '{2'd3, 8'h1C, 32'hFFFF_FFFF, 8'd7,  32'hFFFF_FFFE, 8'd11}, // R11 upper
        '{2'd3, 8'h20, 32'hFFFF_FFFF, 8'd8,  32'h0000_0000, 8'd9},  // R9 disabled
        '{2'd3, 8'h10, 32'hABCD_5678, 8'd4,  32'hABCD_5000, 8'd9},  // R9 address
        '{2'd1, 8'h3C, 32'h0000_0022, 8'd15, 32'h0000_0122, 8'd13}, // R13 line
        '{2'd2, 8'h3C, 32'h0000_FFFF, 8'd15, 32'h0000_01FF, 8'd13}, // R13 pin ro
        '{2'd0, 8'h3C, 32'h0000_0000, 8'd15, 32'h0000_01FF, 8'd6},  // R6 no size
        '{2'd3, 8'h34, 32'hFFFF_FFFF, 8'd13, 32'h0000_0040, 8'd12}, // R12 pointer
        '{2'd3, 8'h2C, 32'h0000_0000, 8'd11, 32'h2468_ABCD, 8'd1},  // R1 subsystem
        '{2'd1, 8'h0B, 32'h0000_0000, 8'd2,  32'h0401_5A00, 8'd1},  // R1 class
        '{2'd2, 8'h07, 32'h0000_0000, 8'd1,  32'h0010_1234, 8'd5}   // R5 offset 3
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        br_wr_en = 1'b0;
    logic [7:0]  wr_off = '0;
    logic [1:0]  wr_size = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic [31:0] br_rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_space_regfile uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off),
        .wr_size(wr_size), .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    cfg_space_regfile #(.HDR(HDR_BRIDGE), .CAP_ON(1'b0), .WIN_EN(6'b000000)) uut_br (
        .clk(clk), .rst_n(rst_n), .wr_en(br_wr_en), .wr_off(wr_off),
        .wr_size(wr_size), .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(br_rd_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input bit bridge, input logic [1:0] sz, input logic [7:0] off,
                            input logic [31:0] dat);
        @(negedge clk);
        wr_en    = !bridge;
        br_wr_en = bridge;
        wr_size  = sz;
        wr_off   = off;
        wr_data  = dat;
        @(negedge clk);
        wr_en    = 1'b0;
        br_wr_en = 1'b0;
        wr_size  = 2'b00;
    endtask

    task automatic rd_dev(input logic [7:0] ix, input string req, input logic [31:0] exp);
        rd_idx = ix;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic rd_br(input logic [7:0] ix, input string req, input logic [31:0] exp);
        rd_idx = ix;
        #1;
        check(req, br_rd_data, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        rd_dev(8'd0,  "R1",  32'h5678_1234);
        rd_dev(8'd2,  "R1",  32'h0401_5A00);
        rd_dev(8'd11, "R1",  32'h2468_ABCD);
        rd_dev(8'd1,  "R12", 32'h0010_0000);
        rd_dev(8'd6,  "R9",  32'h0000_000C);
        rd_dev(8'd5,  "R10", 32'h0000_0001);
        rd_dev(8'd15, "R13", 32'h0000_010B);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            do_write(1'b0, TBL[i].sz, TBL[i].off, TBL[i].dat);
            rd_idx = TBL[i].ridx;
            #1;
            checks++;
            if (rd_data !== TBL[i].exp) begin
                errors++;
                $display("FAIL R%0d (vector %0d): actual=%h expected=%h",
                         TBL[i].req, i, rd_data, TBL[i].exp);
            end
        end

        // R7: out-of-range read indices
        rd_dev(8'd64,  "R7", 32'hFFFF_FFFF);
        rd_dev(8'd255, "R7", 32'hFFFF_FFFF);

        // R7: write and read of the same register in one cycle
        @(negedge clk);
        wr_en = 1'b1; wr_size = 2'b11; wr_off = 8'h10; wr_data = 32'h0000_0000;
        rd_idx = 8'd4;
        #1;
        check("R7", rd_data, 32'hABCD_5000);
        @(negedge clk);
        wr_en = 1'b0; wr_size = 2'b00;
        #1;
        check("R7", rd_data, 32'h0000_0000);

        // R6: strobe low with a valid size
        @(negedge clk);
        wr_en = 1'b0; wr_size = 2'b11; wr_off = 8'h0C; wr_data = 32'hFFFF_FFFF;
        @(negedge clk);
        wr_size = 2'b00;
        rd_dev(8'd3, "R6", 32'h0000_0040);

        // R8 / R12 / R13 on the bridge-flavoured instance
        rd_br(8'd3,  "R8",  32'h0001_0000);
        rd_br(8'd1,  "R12", 32'h0000_0000);
        rd_br(8'd13, "R12", 32'h0000_0000);
        do_write(1'b1, 2'b11, 8'h24, 32'hFFFF_FFFF);
        rd_br(8'd9,  "R8",  32'hFFF0_FFF0);
        do_write(1'b1, 2'b11, 8'h3C, 32'hFFFF_FFFF);
        rd_br(8'd15, "R8",  32'hFFFF_01FF);
        rd_dev(8'd9, "R9",  32'h0000_0000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule